// File: doc/BRIEF.md
# Odd-Digit Decimal Down Counter with Seven-Segment Drive

This block is a synchronous 4-bit down counter that visits only the odd decimal digits. The sequence is 9, 7, 5, 3, 1, and after 1 it returns to 9. All four state bits share one clock and update on its falling edge. The state register is a bank of J-K style flip-flops. Gate-level next-state logic supplies their J and K inputs, written behaviourally. The current digit appears on a 4-bit BCD output and on seven active-high segment lines, so the block can drive a single common-cathode digit directly.

The state machine has five named states: ST_NINE (code 9, the start state), ST_SEVEN (7), ST_FIVE (5), ST_THREE (3) and ST_ONE (1). The transitions are:
- ST_NINE to ST_SEVEN
- ST_SEVEN to ST_FIVE
- ST_FIVE to ST_THREE
- ST_THREE to ST_ONE
- ST_ONE to ST_NINE (the wrap)

A recovery transition takes every other code (0, 2, 4, 6, 8 and 10 to 15) to ST_NINE, so the counter cannot lock up. An active-low reset acts asynchronously and overrides counting. It forces ST_NINE and holds it there for as long as the reset is low.

Top module: `odd_bcd_down_display`

## Requirements
- R1: Driving rst_n low sets count to 9 at once, without waiting for any clock edge.
- R2: While rst_n is held low, count stays at 9 across falling clock edges.
- R3: With rst_n high, each falling clock edge steps count 9 to 7, 7 to 5, 5 to 3 and 3 to 1.
- R4: With rst_n high, the falling clock edge that finds count at 1 sets it to 9.
- R5: A rising clock edge never changes count.
- R6: The next-state logic takes every code that is not 1, 3, 5, 7 or 9 (even codes and codes 10 to 15) to 9 on the next falling edge.
- R7: seg is active high with seg[0]=a, seg[1]=b, seg[2]=c, seg[3]=d, seg[4]=e, seg[5]=f and seg[6]=g. The patterns, written as seg[6:0], are: 1 gives 0000110, 3 gives 1001111, 5 gives 1101101, 7 gives 0000111 and 9 gives 1101111.
- R8: Every code other than 1, 3, 5, 7 or 9 drives seg to all zeros (blank).
- R9: Each state flip-flop follows J-K rules on the falling edge: J=K=0 holds, J=1 K=0 sets, J=0 K=1 clears and J=K=1 toggles. Its own asynchronous reset loads the bank's reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset to the digit 9 |
| count | output | 4 | Current digit in BCD |
| seg | output | 7 | Active-high segment lines, seg[0]=a through seg[6]=g |

## Verification
The illegal codes and the recovery transition cannot be reached from the top-level pins, because reset always loads 9 and the legal cycle never leaves the odd digits. The bench therefore also drives the next-state logic and the segment decoder on their own ports. It sweeps all 16 codes through them and folds the J and K outputs through the J-K rule to obtain the next code. A separate instance of the flip-flop bank is driven with explicit J and K patterns to cover hold, set, clear and toggle. On the top level, reset is asserted in the middle of a cycle to show the immediate load of 9.

// File: rtl/odd_bcd_pkg.sv
`timescale 1ns/1ps
package odd_bcd_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef enum logic [DIGIT_W-1:0] {
        ST_ONE   = 4'd1,
        ST_THREE = 4'd3,
        ST_FIVE  = 4'd5,
        ST_SEVEN = 4'd7,
        ST_NINE  = 4'd9
    } odd_state_e;

    localparam odd_state_e START_STATE = ST_NINE;

    // Segment shapes, bit 0 = a ... bit 6 = g, active high
    localparam logic [SEG_W-1:0] SHAPE_ONE   = 7'b0000110;
    localparam logic [SEG_W-1:0] SHAPE_THREE = 7'b1001111;
    localparam logic [SEG_W-1:0] SHAPE_FIVE  = 7'b1101101;
    localparam logic [SEG_W-1:0] SHAPE_SEVEN = 7'b0000111;
    localparam logic [SEG_W-1:0] SHAPE_NINE  = 7'b1101111;
    localparam logic [SEG_W-1:0] SHAPE_BLANK = '0;
endpackage

// File: rtl/odd_bcd_jk_bank.sv
`timescale 1ns/1ps
module odd_bcd_jk_bank #(
    parameter int WIDTH = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] j,
    input  logic [WIDTH-1:0] k,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_ff
        logic q_bit;

        // Falling-edge J-K cell with asynchronous reset
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_bit <= RST_VAL[i];
            end else begin
                unique case ({j[i], k[i]})
                    2'b00:   q_bit <= q_bit;
                    2'b01:   q_bit <= 1'b0;
                    2'b10:   q_bit <= 1'b1;
                    default: q_bit <= ~q_bit;
                endcase
            end
        end

        assign q[i] = q_bit;
    end
endmodule

// File: rtl/odd_bcd_next.sv
`timescale 1ns/1ps
module odd_bcd_next
    import odd_bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] cur,
    output logic [DIGIT_W-1:0] jin,
    output logic [DIGIT_W-1:0] kin
);
    odd_state_e         nxt;
    logic [DIGIT_W-1:0] nxt_code;

    always_comb begin
        unique case (cur)
            ST_NINE:  nxt = ST_SEVEN;
            ST_SEVEN: nxt = ST_FIVE;
            ST_FIVE:  nxt = ST_THREE;
            ST_THREE: nxt = ST_ONE;
            ST_ONE:   nxt = ST_NINE;   // wrap
            default:  nxt = ST_NINE;   // recovery from any illegal code
        endcase
    end

    assign nxt_code = nxt;

    // Excitation: set bits that must rise, clear bits that must fall
    assign jin = nxt_code & ~cur;
    assign kin = ~nxt_code & cur;
endmodule

// File: rtl/odd_bcd_seg.sv
`timescale 1ns/1ps
module odd_bcd_seg
    import odd_bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] code,
    output logic [SEG_W-1:0]   seg
);
    always_comb begin
        unique case (code)
            ST_ONE:   seg = SHAPE_ONE;
            ST_THREE: seg = SHAPE_THREE;
            ST_FIVE:  seg = SHAPE_FIVE;
            ST_SEVEN: seg = SHAPE_SEVEN;
            ST_NINE:  seg = SHAPE_NINE;
            default:  seg = SHAPE_BLANK;
        endcase
    end
endmodule

// File: rtl/odd_bcd_down_display.sv
`timescale 1ns/1ps
module odd_bcd_down_display
    import odd_bcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [DIGIT_W-1:0] count,
    output logic [SEG_W-1:0]   seg
);
    logic [DIGIT_W-1:0] state_q;
    logic [DIGIT_W-1:0] j_w;
    logic [DIGIT_W-1:0] k_w;

    odd_bcd_next u_next (
        .cur (state_q),
        .jin (j_w),
        .kin (k_w)
    );

    odd_bcd_jk_bank #(
        .WIDTH   (DIGIT_W),
        .RST_VAL (START_STATE)
    ) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .j     (j_w),
        .k     (k_w),
        .q     (state_q)
    );

    odd_bcd_seg u_seg (
        .code (state_q),
        .seg  (seg)
    );

    assign count = state_q;
endmodule

// File: rtl/odd_bcd_down_display_chk.sv
`timescale 1ns/1ps
module odd_bcd_down_display_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] count,
    input logic [6:0] seg
);
    logic legal;
    assign legal = (count == 4'd1) || (count == 4'd3) || (count == 4'd5) ||
                   (count == 4'd7) || (count == 4'd9);

    p_reset_hold_r2: assert property (@(negedge clk)
        !rst_n |-> (count == 4'd9));

    p_step_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (legal && count != 4'd1) |=> (count == $past(count) - 4'd2));

    p_wrap_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (count == 4'd1) |=> (count == 4'd9));

    p_recover_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !legal |=> (count == 4'd9));

    p_shape_one_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (count == 4'd1) |-> (seg == 7'b0000110));

    p_shape_nine_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (count == 4'd9) |-> (seg == 7'b1101111));

    p_blank_r8: assert property (@(negedge clk) disable iff (!rst_n)
        !legal |-> (seg == 7'b0000000));
endmodule

bind odd_bcd_down_display odd_bcd_down_display_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count),
    .seg   (seg)
);

// File: tb/odd_bcd_down_display_test.sv
`timescale 1ns/1ps
module odd_bcd_down_display_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] count;
    logic [6:0] seg;

    logic [3:0] nx_cur;
    logic [3:0] nx_j, nx_k;
    logic [3:0] sd_code;
    logic [6:0] sd_seg;
    logic       b_rst_n;
    logic [3:0] b_j, b_k, b_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    odd_bcd_down_display uut (.clk(clk), .rst_n(rst_n), .count(count), .seg(seg));
    odd_bcd_next         u_nx (.cur(nx_cur), .jin(nx_j), .kin(nx_k));
    odd_bcd_seg          u_sd (.code(sd_code), .seg(sd_seg));
    odd_bcd_jk_bank #(.WIDTH(4), .RST_VAL(4'd0)) u_bank (
        .clk(clk), .rst_n(b_rst_n), .j(b_j), .k(b_k), .q(b_q));

    function automatic logic [3:0] exp_next(input logic [3:0] v);
        if (v == 4'd1) return 4'd9;
        if (v <= 4'd9 && v[0]) return v - 4'd2;
        return 4'd9;
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        case (v)
            4'd1:    return 7'b0000110;
            4'd3:    return 7'b1001111;
            4'd5:    return 7'b1101101;
            4'd7:    return 7'b0000111;
            4'd9:    return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] expv;
        logic [3:0] folded;
        rst_n = 1'b1;
        b_rst_n = 1'b1;
        b_j = '0;
        b_k = '0;
        nx_cur = '0;
        sd_code = '0;
        #1 rst_n = 1'b0;
        b_rst_n = 1'b0;
        #0.5;
        // R1: reset loads 9 before any clock edge
        check("R1 async reset", count, 9);
        check("R7 seg of 9", seg, 7'b1101111);
        check("R9 bank reset", b_q, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #0.5;
            check("R2 hold in reset", count, 9);
        end
        @(posedge clk); #0.5;
        rst_n = 1'b1;
        b_rst_n = 1'b1;
        expv = 4'd9;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #0.5;
            if (expv == 4'd1) begin
                expv = 4'd9;
                check("R4 wrap", count, expv);
            end else begin
                expv = expv - 4'd2;
                check("R3 step", count, expv);
            end
            check("R7 seg", seg, exp_seg(expv));
            @(posedge clk); #0.5;
            check("R5 rising edge no change", count, expv);
        end
        // mid-sequence asynchronous reset
        while (count != 4'd3) begin
            @(negedge clk); #0.5;
        end
        @(posedge clk); #0.5;
        rst_n = 1'b0;
        #0.3;
        check("R1 async reset mid cycle", count, 9);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #0.5;
            check("R2 hold in reset", count, 9);
        end
        @(posedge clk); #0.5;
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        check("R3 step after reset", count, 7);

        // exhaustive sweep of next-state logic and decoder
        for (int v = 0; v < 16; v++) begin
            nx_cur = 4'(v);
            sd_code = 4'(v);
            #0.2;
            folded = (nx_j & ~nx_cur) | (~nx_k & nx_cur);
            if (v == 1)
                check("R4 wrap code", folded, exp_next(4'(v)));
            else if (v <= 9 && v % 2 == 1)
                check("R3 step code", folded, exp_next(4'(v)));
            else
                check("R6 recovery", folded, 9);
            if (v <= 9 && v % 2 == 1)
                check("R7 shape", sd_seg, exp_seg(4'(v)));
            else
                check("R8 blank", sd_seg, 0);
        end

        // J-K bank behaviour
        @(posedge clk); b_j = 4'hF; b_k = 4'h0;
        @(negedge clk); #0.5; check("R9 set", b_q, 4'hF);
        @(posedge clk); b_j = 4'h0; b_k = 4'h0;
        @(negedge clk); #0.5; check("R9 hold", b_q, 4'hF);
        @(posedge clk); b_j = 4'hF; b_k = 4'hF;
        @(negedge clk); #0.5; check("R9 toggle", b_q, 4'h0);
        @(posedge clk); b_j = 4'h5; b_k = 4'h0;
        @(negedge clk); #0.5; check("R9 set pattern", b_q, 4'h5);
        @(posedge clk); b_j = 4'h0; b_k = 4'h1;
        @(negedge clk); #0.5; check("R9 clear", b_q, 4'h4);
        @(posedge clk); b_j = 4'hA; b_k = 4'hA;
        @(negedge clk); #0.5; check("R9 toggle pattern", b_q, 4'hE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule